// File: doc/BRIEF.md
# Branch Target Buffer

The block is a direct-mapped table that the fetch stage reads in the same cycle as it sends a program counter. It returns a hit flag, a taken prediction and the next fetch address. A hit whose direction counter leans taken steers fetch to the stored target, so a taken branch costs no stall. On a miss, or on a hit whose counter leans not taken, fetch goes on to the next sequential word at PC+4. A PC that is absent from the table therefore counts as a branch predicted not taken.

Branches that resolve later in the pipeline come back through an update port. That port carries the branch PC, the resolved target and the outcome. A taken branch either creates its entry or strengthens it. A not-taken branch weakens a matching entry and evicts it once the counter reaches its lowest value. Each entry holds the full branch PC, the target, a saturating direction counter and a valid bit.

Top module: `branchTargetBuffer`

## Requirements
- R1: After reset every entry is invalid, so any lookup returns predHit=0.
- R2: Word address bits fetchPc[IDX_W+1:2] select the entry. A lookup hits only when that entry is valid and its stored branch PC equals the whole fetchPc. A different PC that maps to the same entry misses.
- R3: On a miss, predHit=0, predTaken=0 and nextPc=fetchPc+4.
- R4: On a hit whose counter has its top bit set (value 2 or 3 for a 2-bit counter), predHit=1, predTaken=1 and nextPc is the stored target. predTaken is never 1 without predHit.
- R5: On a hit whose counter has its top bit clear (value 1), predHit=1, predTaken=0 and nextPc=fetchPc+4.
- R6: A taken update whose PC does not match the valid entry at its index allocates that entry. If another branch holds the entry, the update overwrites it. The new entry stores the PC and the target and starts with the counter at weakly taken (2).
- R7: A taken update whose PC matches its entry increments the counter, saturating at 3, and replaces the stored target with the new one.
- R8: A not-taken update whose PC matches its entry decrements the counter. When the counter reaches 0, the entry becomes invalid and later lookups miss.
- R9: A not-taken update for a PC that is not in the table changes nothing, including the entry held by another branch at the same index.
- R10: An update takes effect at the clock edge that samples it. A lookup in the same cycle sees the contents as they were before the update; a lookup in the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, clears all valid bits |
| fetchPc | input | PC_W | Fetch address to look up |
| predHit | output | 1 | Lookup found a matching valid entry |
| predTaken | output | 1 | Hit whose counter predicts taken |
| nextPc | output | PC_W | Predicted next fetch address |
| updValid | input | 1 | Resolved-branch update present this cycle |
| updPc | input | PC_W | PC of the resolved branch |
| updTarget | input | PC_W | Resolved target of the branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The lookup outputs are combinational, so predHit, predTaken and nextPc are due in the same cycle as fetchPc. An update changes the table at the next rising edge and is first visible to a lookup in the cycle after it is presented. The bench drives each cycle's inputs on the falling edge and samples the outputs 1 ns later. Its reference table applies the cycle's update only after the rising edge that follows, so same-cycle lookups are checked against the old contents and later lookups against the new.

// File: rtl/btbPkg.sv
package btbPkg;

  // Strobes from control to datapath, refreshed every cycle.
  typedef struct packed {
    logic wrEn;        // write the entry at the update index
    logic wrPcTarget;  // load branch PC and target into that entry
    logic validVal;    // valid bit written with wrEn
    logic ctrLoad;     // counter := weakly taken
    logic ctrInc;      // counter := saturating increment
    logic ctrDec;      // counter := decrement
    logic selTarget;   // steer nextPc to stored target
  } btbStrobe_t;

endpackage

// File: rtl/btbDatapath.sv
module btbDatapath
  import btbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic [PC_W-1:0]  updPc,
  input  logic [PC_W-1:0]  updTarget,
  input  btbStrobe_t       strobe,
  output logic             lkHit,
  output logic [CTR_W-1:0] lkCtr,
  output logic             upMatch,
  output logic [CTR_W-1:0] upCtr,
  output logic [PC_W-1:0]  nextPc
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] WEAK_T  = {1'b1, {(CTR_W-1){1'b0}}};

  logic [ENTRIES-1:0] entValid;
  logic [PC_W-1:0]    entPc     [ENTRIES];
  logic [PC_W-1:0]    entTarget [ENTRIES];
  logic [CTR_W-1:0]   entCtr    [ENTRIES];

  logic [IDX_W-1:0] lkIdx;
  logic [IDX_W-1:0] upIdx;
  logic [CTR_W-1:0] ctrNext;

  assign lkIdx = fetchPc[IDX_W+1:2];
  assign upIdx = updPc[IDX_W+1:2];

  // fetch-side read
  assign lkHit  = entValid[lkIdx] && (entPc[lkIdx] == fetchPc);
  assign lkCtr  = entCtr[lkIdx];
  assign nextPc = strobe.selTarget ? entTarget[lkIdx] : fetchPc + PC_W'(4);

  // update-side read
  assign upMatch = entValid[upIdx] && (entPc[upIdx] == updPc);
  assign upCtr   = entCtr[upIdx];

  always_comb begin
    ctrNext = upCtr;
    if (strobe.ctrLoad)
      ctrNext = WEAK_T;
    else if (strobe.ctrInc)
      ctrNext = (upCtr == CTR_MAX) ? CTR_MAX : upCtr + CTR_W'(1);
    else if (strobe.ctrDec)
      ctrNext = upCtr - CTR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      entValid <= '0;
    else if (strobe.wrEn)
      entValid[upIdx] <= strobe.validVal;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      entCtr[upIdx] <= ctrNext;
      if (strobe.wrPcTarget) begin
        entPc[upIdx]     <= updPc;
        entTarget[upIdx] <= updTarget;
      end
    end
  end

endmodule

// File: rtl/btbControl.sv
module btbControl
  import btbPkg::*;
#(
  parameter int CTR_W = 2
) (
  input  logic             lkHit,
  input  logic [CTR_W-1:0] lkCtr,
  input  logic             upMatch,
  input  logic [CTR_W-1:0] upCtr,
  input  logic             updValid,
  input  logic             updTaken,
  output btbStrobe_t       strobe
);

  localparam logic [CTR_W-1:0] CTR_ONE = CTR_W'(1);

  always_comb begin
    strobe           = '0;
    strobe.selTarget = lkHit && lkCtr[CTR_W-1];
    if (updValid) begin
      if (updTaken) begin
        strobe.wrEn       = 1'b1;
        strobe.wrPcTarget = 1'b1;
        strobe.validVal   = 1'b1;
        strobe.ctrInc     = upMatch;
        strobe.ctrLoad    = !upMatch;
      end else if (upMatch) begin
        strobe.wrEn     = 1'b1;
        strobe.ctrDec   = 1'b1;
        strobe.validVal = (upCtr != CTR_ONE);
      end
    end
  end

endmodule

// File: rtl/branchTargetBuffer.sv
module branchTargetBuffer
  import btbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int CTR_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  output logic            predHit,
  output logic            predTaken,
  output logic [PC_W-1:0] nextPc,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic [PC_W-1:0] updTarget,
  input  logic            updTaken
);

  btbStrobe_t       strobe;
  logic             lkHit;
  logic [CTR_W-1:0] lkCtr;
  logic             upMatch;
  logic [CTR_W-1:0] upCtr;

  btbDatapath #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .fetchPc   (fetchPc),
    .updPc     (updPc),
    .updTarget (updTarget),
    .strobe    (strobe),
    .lkHit     (lkHit),
    .lkCtr     (lkCtr),
    .upMatch   (upMatch),
    .upCtr     (upCtr),
    .nextPc    (nextPc)
  );

  btbControl #(.CTR_W(CTR_W)) uCtl (
    .lkHit    (lkHit),
    .lkCtr    (lkCtr),
    .upMatch  (upMatch),
    .upCtr    (upCtr),
    .updValid (updValid),
    .updTaken (updTaken),
    .strobe   (strobe)
  );

  assign predHit   = lkHit;
  assign predTaken = strobe.selTarget;

endmodule

// File: rtl/btbChecker.sv
module btbChecker
  import btbPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int CTR_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [PC_W-1:0]  fetchPc,
  input logic             predHit,
  input logic             predTaken,
  input logic [PC_W-1:0]  nextPc,
  input logic             updValid,
  input logic [PC_W-1:0]  updPc,
  input logic [PC_W-1:0]  updTarget,
  input logic             updTaken,
  input btbStrobe_t       strobe,
  input logic             upMatch,
  input logic [CTR_W-1:0] upCtr
);

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    !predHit |-> (!predTaken && nextPc == fetchPc + PC_W'(4))); // R3

  AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> predHit); // R4

  AST_WEAK_HIT_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    (predHit && !predTaken) |-> nextPc == fetchPc + PC_W'(4)); // R5

  AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken && !upMatch) |-> (strobe.wrEn && strobe.ctrLoad && strobe.validVal)); // R6

  AST_TAKEN_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken) |=> ((fetchPc != $past(updPc)) ||
                                (predHit && predTaken && nextPc == $past(updTarget)))); // R7

  AST_EVICT_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && upMatch && upCtr == CTR_W'(1)) |-> (strobe.wrEn && !strobe.validVal)); // R8

  AST_ABSENT_NOT_TAKEN_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && !upMatch) |-> !strobe.wrEn); // R9

endmodule

bind branchTargetBuffer btbChecker #(.PC_W(PC_W), .CTR_W(CTR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .fetchPc   (fetchPc),
  .predHit   (predHit),
  .predTaken (predTaken),
  .nextPc    (nextPc),
  .updValid  (updValid),
  .updPc     (updPc),
  .updTarget (updTarget),
  .updTaken  (updTaken),
  .strobe    (strobe),
  .upMatch   (upMatch),
  .upCtr     (upCtr)
);

// File: tb/sim_branchTargetBuffer.sv
`timescale 1ns/1ps
module sim_branchTargetBuffer;

  localparam int PC_W    = 32;
  localparam int IDX_W   = 4;
  localparam int ENTRIES = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [PC_W-1:0] fetchPc = '0;
  logic            predHit;
  logic            predTaken;
  logic [PC_W-1:0] nextPc;
  logic            updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic [PC_W-1:0] updTarget = '0;
  logic            updTaken = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference table built from the requirements
  bit              mValid [ENTRIES];
  logic [PC_W-1:0] mPc    [ENTRIES];
  logic [PC_W-1:0] mTgt   [ENTRIES];
  int              mCtr   [ENTRIES];

  always #2 clk = ~clk;

  branchTargetBuffer #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(2)) u0 (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .predHit(predHit),
    .predTaken(predTaken), .nextPc(nextPc), .updValid(updValid),
    .updPc(updPc), .updTarget(updTarget), .updTaken(updTaken)
  );

  function automatic int idxOf(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic bit expHit(logic [PC_W-1:0] pc);
    return mValid[idxOf(pc)] && mPc[idxOf(pc)] == pc;
  endfunction

  function automatic bit expTaken(logic [PC_W-1:0] pc);
    return expHit(pc) && mCtr[idxOf(pc)] >= 2;
  endfunction

  function automatic logic [PC_W-1:0] expNext(logic [PC_W-1:0] pc);
    return expTaken(pc) ? mTgt[idxOf(pc)] : pc + 32'd4;
  endfunction

  task automatic modelUpdate(bit uv, logic [PC_W-1:0] upc, logic [PC_W-1:0] utgt, bit utk);
    int i;
    bit m;
    if (!uv) return;
    i = idxOf(upc);
    m = mValid[i] && mPc[i] == upc;
    if (utk) begin
      mCtr[i]   = m ? ((mCtr[i] == 3) ? 3 : mCtr[i] + 1) : 2;
      mValid[i] = 1'b1;
      mPc[i]    = upc;
      mTgt[i]   = utgt;
    end else if (m) begin
      mCtr[i] = mCtr[i] - 1;
      if (mCtr[i] == 0) mValid[i] = 1'b0;
    end
  endtask

  task automatic check(string tag, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample 1 ns later, model follows the rising edge
  task automatic cycle(logic [PC_W-1:0] pc, bit uv, logic [PC_W-1:0] upc,
                       logic [PC_W-1:0] utgt, bit utk, string tag);
    string t;
    @(negedge clk);
    fetchPc = pc; updValid = uv; updPc = upc; updTarget = utgt; updTaken = utk;
    #1;
    t = tag;
    if (t == "") t = !expHit(pc) ? "R3" : (expTaken(pc) ? "R4" : "R5");
    check(t, "predHit",   {31'd0, predHit},   {31'd0, expHit(pc)});
    check(t, "predTaken", {31'd0, predTaken}, {31'd0, expTaken(pc)});
    check(t, "nextPc",    nextPc,             expNext(pc));
    @(posedge clk);
    modelUpdate(uv, upc, utgt, utk);
  endtask

  task automatic look(logic [PC_W-1:0] pc, string tag);
    cycle(pc, 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  localparam logic [PC_W-1:0] PA = 32'h0000_1010; // index 4
  localparam logic [PC_W-1:0] PB = 32'h0004_2010; // index 4, other branch
  localparam logic [PC_W-1:0] T1 = 32'h0000_8000;
  localparam logic [PC_W-1:0] T2 = 32'h0000_9100;
  localparam logic [PC_W-1:0] T3 = 32'h0000_A200;

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      mValid[i] = 1'b0; mPc[i] = '0; mTgt[i] = '0; mCtr[i] = 0;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: empty after reset
    look(PA, "R1");
    look(32'h0000_0000, "R1");
    // R10: allocate, same-cycle lookup sees old contents
    cycle(PA, 1'b1, PA, T1, 1'b1, "R10");
    look(PA, "R6");
    // R2: alias on same index misses
    look(PB, "R2");
    // R9: not-taken for absent PC leaves the resident entry
    cycle(PA, 1'b1, PB, T3, 1'b0, "R9");
    look(PA, "R9");
    // R8 then R5: one not-taken drops to 1, still a hit but sequential
    cycle(PA, 1'b1, PA, T1, 1'b0, "R8");
    look(PA, "R5");
    cycle(PA, 1'b1, PA, T1, 1'b0, "R8");
    look(PA, "R8");
    // R7: saturating increment and target replacement
    cycle(PA, 1'b1, PA, T1, 1'b1, "R6");
    cycle(PA, 1'b1, PA, T2, 1'b1, "R7");
    cycle(PA, 1'b1, PA, T2, 1'b1, "R7");
    cycle(PA, 1'b1, PA, T2, 1'b1, "R7");
    cycle(PA, 1'b1, PA, T2, 1'b0, "R7");
    cycle(PA, 1'b1, PA, T2, 1'b0, "R7");
    look(PA, "R7");
    // R6: overwrite by another branch
    cycle(PB, 1'b1, PB, T3, 1'b1, "R6");
    look(PA, "R6");
    look(PB, "R6");
    look(PB + 32'd4, "R3");

    // random traffic over a small PC pool so aliasing and evictions occur
    for (int n = 0; n < 4000; n++) begin
      logic [PC_W-1:0] fp, up, ut;
      fp = (($urandom % 2) ? 32'h0004_2000 : 32'h0000_1000) + 32'(($urandom % ENTRIES) * 4);
      up = (($urandom % 2) ? 32'h0004_2000 : 32'h0000_1000) + 32'(($urandom % ENTRIES) * 4);
      ut = {16'h0001, 14'($urandom), 2'b00};
      cycle(fp, ($urandom % 10) < 6, up, ut, ($urandom % 10) < 5, "");
    end

    finishRun();
  end

endmodule